// File: doc/BRIEF.md
# Quad Digital Potentiometer Wiper Controller

This block is the serial control logic of a four-channel digital potentiometer. A host reaches it over a mode-0 SPI link: chip select low, data in sampled on rising SCK, and data out updated after falling SCK. While the chip select is low, the first byte received is an instruction. Some instructions are followed by a data byte or by a read-back byte. The block keeps one 6-bit wiper register per channel, and these registers drive the tap selection of the analog arrays. It also keeps sixteen 6-bit retained registers, four per channel, that model the non-volatile store.

Through the link the host can read and write any wiper or retained register. It can copy a wiper into one of its own channel's retained slots, or restore a wiper from one of them. A stepping mode moves one wiper by a single tap for each bit clocked in. Every accepted store into the retained bank starts a busy window of `NV_BUSY_CYCLES` system clocks. Further stores are discarded until that window closes, which stands in for the programming time of real cells.

SPI pins are asynchronous to `clk` and pass through two-stage synchronizers, so SCK must stay at least four `clk` periods in each phase. The link has no back-pressure. A byte is taken when its eighth bit arrives, and the retained-store busy flag is the only flow indication to the host.

Top module: `dpot_ctrl`

## Requirements
- R1: The instruction byte is sent MSB first and sampled on rising SCK while CSN is low. Bits [7:4] carry the operation code, bits [3:2] pick the retained slot (0..3) and bits [1:0] pick the channel (0..3).
- R2: Code 4'b1010 loads bits [5:0] of the next byte into the chosen wiper when that byte's eighth bit arrives. Wiper n appears on `wiper_taps[6n+5:6n]`.
- R3: Codes 4'b1001 (wiper) and 4'b1011 (retained slot) return {2'b00, value} MSB first over the next eight SCK periods. Each bit is driven after a falling SCK edge. SDO is 0 whenever no read is in progress and while CSN is high.
- R4: Code 4'b1100 stores bits [5:0] of the next byte into the chosen channel's chosen retained slot.
- R5: Code 4'b1101 copies the chosen retained slot into the channel's wiper, and code 4'b1110 copies the wiper into that slot. Both act when the instruction byte completes.
- R6: After an accepted retained store, `nv_busy` is high for exactly `NV_BUSY_CYCLES` clocks. Stores issued (4'b1100 or 4'b1110) while it is high are discarded and do not extend the window.
- R7: Code 4'b0010 enters stepping mode. Each following SDI bit moves the chosen wiper up one tap (bit 1) or down one tap (bit 0), holding at 63 and at 0 without wrapping.
- R8: Any other operation code changes nothing until CSN goes high.
- R9: CSN high discards a partial byte and ends any mode. Wipers and retained slots do not change while CSN is high, and the next selection starts with an instruction byte.
- R10: After reset all wipers and retained slots are 0, `nv_busy` is low and SDO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous-assert reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Chip select, active low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial read data |
| wiper_taps | output | NUM_POTS*TAP_W | Wiper positions, channel 0 in the low bits |
| nv_busy | output | 1 | Retained-store programming window active |

## Verification
A retained store can land in the same cycle that the busy window from an earlier store is still counting down. When that happens the block must both refuse the new store and leave the count untouched. The bench provokes this by issuing a second 4'b1100 store and then a 4'b1110 copy right after a first store, well inside a widened busy window. It judges the result in two ways: the number of busy cycles over the whole episode must equal exactly one window, and reading back both slots after the window closes must return the first store and the untouched prior contents. Stepping at the rails and loads in the same channel are also swept, to confirm that a saturated step leaves the wiper exactly where it was.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [3:0] OP_STEP  = 4'b0010;
  localparam logic [3:0] OP_RD_W  = 4'b1001;
  localparam logic [3:0] OP_WR_W  = 4'b1010;
  localparam logic [3:0] OP_RD_NV = 4'b1011;
  localparam logic [3:0] OP_WR_NV = 4'b1100;
  localparam logic [3:0] OP_NV2W  = 4'b1101;
  localparam logic [3:0] OP_W2NV  = 4'b1110;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_STEP,
    ST_HOLD
  } seq_state_e;
endpackage

// File: rtl/dpot_spi_rx.sv
module dpot_spi_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              csn,
  input  logic              sdi,
  output logic              sel,
  output logic              bit_stb,
  output logic              bit_val,
  output logic              fall_stb,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0]        sck_q;
  logic [1:0]        csn_q;
  logic [1:0]        sdi_q;
  logic [BYTE_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      csn_q <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      csn_q <= {csn_q[0], csn};
      sdi_q <= {sdi_q[0], sdi};
    end
  end

  assign sel      = ~csn_q[1];
  assign bit_stb  = sel & sck_q[1] & ~sck_q[2];
  assign fall_stb = sel & ~sck_q[1] & sck_q[2];
  assign bit_val  = sdi_q[1];
  assign byte_stb = bit_stb && (cnt == CNT_W'(BYTE_W - 1));
  assign byte_val = {sh, bit_val};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (!sel) begin
      cnt <= '0;
    end else if (bit_stb) begin
      sh  <= {sh[BYTE_W-3:0], bit_val};
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dpot_nv_bank.sv
module dpot_nv_bank #(
  parameter int NUM_POTS    = 4,
  parameter int NV_SLOTS    = 4,
  parameter int TAP_W       = 6,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      we,
  input  logic [$clog2(NUM_POTS*NV_SLOTS)-1:0]      addr,
  input  logic [TAP_W-1:0]                          wdata,
  output logic [TAP_W-1:0]                          rdata,
  output logic                                      busy
);
  localparam int DEPTH = NUM_POTS * NV_SLOTS;
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [TAP_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] left;

  assign busy  = (left != '0);
  assign rdata = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      left <= '0;
    end else if (we && !busy) begin
      mem[addr] <= wdata;
      left      <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
  parameter int NUM_POTS = 4,
  parameter int TAP_W    = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               ld,
  input  logic [$clog2(NUM_POTS)-1:0]        ld_pot,
  input  logic [TAP_W-1:0]                   ld_val,
  input  logic                               step,
  input  logic                               step_up,
  input  logic [$clog2(NUM_POTS)-1:0]        step_pot,
  output logic [NUM_POTS*TAP_W-1:0]          taps
);
  localparam int POT_W = $clog2(NUM_POTS);
  localparam logic [TAP_W-1:0] TOP = '1;

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_pot
    logic [TAP_W-1:0] pos;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos <= '0;
      end else if (ld && ld_pot == POT_W'(g)) begin
        pos <= ld_val;
      end else if (step && step_pot == POT_W'(g)) begin
        if (step_up && pos != TOP) pos <= pos + 1'b1;
        else if (!step_up && pos != '0) pos <= pos - 1'b1;
      end
    end
    assign taps[g*TAP_W +: TAP_W] = pos;
  end
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int NUM_POTS       = 4,
  parameter int NV_SLOTS       = 4,
  parameter int TAP_W          = 6,
  parameter int NV_BUSY_CYCLES = 250000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      spi_sck,
  input  logic                      spi_csn,
  input  logic                      spi_sdi,
  output logic                      spi_sdo,
  output logic [NUM_POTS*TAP_W-1:0] wiper_taps,
  output logic                      nv_busy
);
  localparam int BYTE_W = 8;
  localparam int POT_W  = $clog2(NUM_POTS);
  localparam int SLOT_W = $clog2(NV_SLOTS);
  localparam int ADDR_W = $clog2(NUM_POTS * NV_SLOTS);
  localparam int PAD_W  = BYTE_W - TAP_W;

  logic              sel, bit_stb, bit_val, fall_stb, byte_stb;
  logic [BYTE_W-1:0] byte_val;

  dpot_spi_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .sdi(spi_sdi),
    .sel(sel), .bit_stb(bit_stb), .bit_val(bit_val), .fall_stb(fall_stb),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  seq_state_e        st;
  logic [3:0]        op_q;
  logic [POT_W-1:0]  pot_q, cur_pot;
  logic [SLOT_W-1:0] slot_q, cur_slot;
  logic [BYTE_W-1:0] tx_sh;
  logic              sdo_q;
  logic [ADDR_W-1:0] nv_addr;
  logic [TAP_W-1:0]  cur_w, nv_rdata, nv_wdata, w_ld_val;
  logic              nv_we, w_ld, w_step, w_step_up;

  assign cur_pot  = (st == ST_CMD) ? byte_val[POT_W-1:0] : pot_q;
  assign cur_slot = (st == ST_CMD) ? byte_val[2 +: SLOT_W] : slot_q;
  assign nv_addr  = ADDR_W'(cur_pot) * ADDR_W'(NV_SLOTS) + ADDR_W'(cur_slot);
  assign cur_w    = wiper_taps[cur_pot*TAP_W +: TAP_W];
  assign spi_sdo  = sdo_q;

  always_comb begin
    w_ld      = 1'b0;
    w_ld_val  = '0;
    w_step    = 1'b0;
    w_step_up = 1'b0;
    nv_we     = 1'b0;
    nv_wdata  = '0;
    unique case (st)
      ST_CMD: if (byte_stb) begin
        if (byte_val[7:4] == OP_NV2W) begin
          w_ld     = 1'b1;
          w_ld_val = nv_rdata;
        end else if (byte_val[7:4] == OP_W2NV) begin
          nv_we    = 1'b1;
          nv_wdata = cur_w;
        end
      end
      ST_DATA: if (byte_stb) begin
        if (op_q == OP_WR_W) begin
          w_ld     = 1'b1;
          w_ld_val = byte_val[TAP_W-1:0];
        end else begin
          nv_we    = 1'b1;
          nv_wdata = byte_val[TAP_W-1:0];
        end
      end
      ST_STEP: if (bit_stb) begin
        w_step    = 1'b1;
        w_step_up = bit_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CMD;
      op_q   <= '0;
      pot_q  <= '0;
      slot_q <= '0;
      tx_sh  <= '0;
      sdo_q  <= 1'b0;
    end else if (!sel) begin
      st    <= ST_CMD;
      tx_sh <= '0;
      sdo_q <= 1'b0;
    end else begin
      unique case (st)
        ST_CMD: if (byte_stb) begin
          op_q   <= byte_val[7:4];
          pot_q  <= cur_pot;
          slot_q <= cur_slot;
          case (byte_val[7:4])
            OP_RD_W:  begin tx_sh <= {{PAD_W{1'b0}}, cur_w};    st <= ST_READ; end
            OP_RD_NV: begin tx_sh <= {{PAD_W{1'b0}}, nv_rdata}; st <= ST_READ; end
            OP_WR_W, OP_WR_NV: st <= ST_DATA;
            OP_STEP:  st <= ST_STEP;
            default:  st <= ST_HOLD;
          endcase
        end
        ST_DATA: if (byte_stb) st <= ST_HOLD;
        ST_READ: if (fall_stb) begin
          sdo_q <= tx_sh[BYTE_W-1];
          tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  dpot_wiper_bank #(.NUM_POTS(NUM_POTS), .TAP_W(TAP_W)) u_wipers (
    .clk(clk), .rst_n(rst_n), .ld(w_ld), .ld_pot(pot_sel_ld()), .ld_val(w_ld_val),
    .step(w_step), .step_up(w_step_up), .step_pot(pot_q), .taps(wiper_taps)
  );

  function automatic logic [POT_W-1:0] pot_sel_ld();
    return cur_pot;
  endfunction

  dpot_nv_bank #(
    .NUM_POTS(NUM_POTS), .NV_SLOTS(NV_SLOTS), .TAP_W(TAP_W), .BUSY_CYCLES(NV_BUSY_CYCLES)
  ) u_nv (
    .clk(clk), .rst_n(rst_n), .we(nv_we), .addr(nv_addr), .wdata(nv_wdata),
    .rdata(nv_rdata), .busy(nv_busy)
  );
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
  parameter int NUM_POTS = 4,
  parameter int TAP_W    = 6,
  parameter int BUSY     = 250000
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      spi_csn,
  input logic                      spi_sdo,
  input logic [NUM_POTS*TAP_W-1:0] wiper_taps,
  input logic                      nv_busy,
  input logic                      step,
  input logic                      step_up,
  input logic [$clog2(NUM_POTS)-1:0] step_pot
);
  localparam logic [TAP_W-1:0] TOP = '1;

  logic [31:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (nv_busy) busy_run <= busy_run + 1;
    else busy_run <= '0;
  end

  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_busy) |-> busy_run == 32'(BUSY));

  assert_sdo_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_sdo);

  assert_hold_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> $stable(wiper_taps));

  assert_top_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && wiper_taps[step_pot*TAP_W +: TAP_W] == TOP) |=> $stable(wiper_taps));

  assert_bottom_rail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && wiper_taps[step_pot*TAP_W +: TAP_W] == '0) |=> $stable(wiper_taps));

  assert_step_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && wiper_taps[step_pot*TAP_W +: TAP_W] != TOP) |=> !$stable(wiper_taps));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(
  .NUM_POTS(NUM_POTS), .TAP_W(TAP_W), .BUSY(NV_BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sdo(spi_sdo),
  .wiper_taps(wiper_taps), .nv_busy(nv_busy), .step(w_step),
  .step_up(w_step_up), .step_pot(pot_q)
);

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
  localparam int H    = 4;
  localparam int BUSY = 300;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_sdi = 1'b0;
  logic spi_sdo, nv_busy;
  logic [23:0] wiper_taps;

  int total = 0, bad = 0, busy_cnt = 0;
  logic [5:0] exp_w [4];
  logic [5:0] exp_nv [16];

  always #2 clk = ~clk;

  dpot_ctrl #(.NV_BUSY_CYCLES(BUSY)) i_dpot_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn),
    .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .wiper_taps(wiper_taps), .nv_busy(nv_busy)
  );

  always @(negedge clk) if (nv_busy === 1'b1) busy_cnt++;

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=completion");
    finish_run();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] packed_exp();
    logic [23:0] v;
    for (int p = 0; p < 4; p++) v[p*6 +: 6] = exp_w[p];
    return v;
  endfunction

  function automatic logic [5:0] step_model(input logic [5:0] v, input logic up);
    if (up) return (v == 6'd63) ? v : v + 6'd1;
    return (v == 6'd0) ? v : v - 6'd1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on();
    spi_csn = 1'b0;
    tick(H);
  endtask

  task automatic sel_off();
    tick(H);
    spi_csn = 1'b1;
    tick(2 * H);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      spi_sdi = tx[i];
      tick(H);
      rx[i] = spi_sdo;
      spi_sck = 1'b1;
      tick(H);
      spi_sck = 1'b0;
    end
  endtask

  task automatic txn1(input logic [7:0] c);
    logic [7:0] junk;
    sel_on();
    xbits(c, 8, junk);
    sel_off();
  endtask

  task automatic txn2(input logic [7:0] c, input logic [7:0] d, output logic [7:0] rx);
    logic [7:0] junk;
    sel_on();
    xbits(c, 8, junk);
    xbits(d, 8, rx);
    sel_off();
  endtask

  task automatic wait_idle();
    while (nv_busy) tick(1);
    tick(2);
  endtask

  task automatic rd_wiper(input int p, input string tag);
    logic [7:0] rx;
    txn2({4'b1001, 2'b00, 2'(p)}, 8'h00, rx);
    chk(tag, rx, {2'b00, exp_w[p]});
    chk("R3 sdo low after deselect", spi_sdo, 1'b0);
  endtask

  task automatic rd_nv(input int p, input int s, input string tag);
    logic [7:0] rx;
    txn2({4'b1011, 2'(s), 2'(p)}, 8'h00, rx);
    chk(tag, rx, {2'b00, exp_nv[p*4+s]});
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] pat;
    for (int p = 0; p < 4; p++) exp_w[p] = '0;
    for (int i = 0; i < 16; i++) exp_nv[i] = '0;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R10: reset state at the ports and in every retained slot
    chk("R10 taps", wiper_taps, 24'h0);
    chk("R10 busy", nv_busy, 1'b0);
    chk("R10 sdo", spi_sdo, 1'b0);
    for (int i = 0; i < 16; i++) rd_nv(i / 4, i % 4, "R10 nv slot");

    // R1 R2 R3: exhaustive wiper write/read on every channel
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 64; v++) begin
        logic [5:0] wv;
        wv = 6'((v * 37 + p * 11) % 64);
        txn2({4'b1010, 2'b11, 2'(p)}, {2'b11, wv}, rx);
        exp_w[p] = wv;
        chk("R2 wiper write", wiper_taps, packed_exp());
        rd_wiper(p, "R3 wiper read");
      end

    // R4 R6: store every retained slot, busy window exact
    for (int i = 0; i < 16; i++) begin
      logic [5:0] nv;
      nv = 6'((i * 23 + 5) % 64);
      busy_cnt = 0;
      txn2({4'b1100, 2'(i % 4), 2'(i / 4)}, {2'b10, nv}, rx);
      exp_nv[i] = nv;
      wait_idle();
      chk("R6 busy length", busy_cnt, BUSY);
    end
    for (int i = 0; i < 16; i++) rd_nv(i / 4, i % 4, "R4 nv read");

    // R5: restore wiper from slot, then copy wiper to slot
    for (int p = 0; p < 4; p++) begin
      txn1({4'b1101, 2'(3 - p), 2'(p)});
      exp_w[p] = exp_nv[p*4 + 3 - p];
      chk("R5 nv to wiper", wiper_taps, packed_exp());
    end
    for (int p = 0; p < 4; p++) begin
      txn2({4'b1010, 2'b00, 2'(p)}, 8'(p * 9 + 40), rx);
      exp_w[p] = 6'(p * 9 + 40);
      busy_cnt = 0;
      txn1({4'b1110, 2'(p), 2'(p)});
      exp_nv[p*4 + p] = exp_w[p];
      wait_idle();
      chk("R6 busy after copy", busy_cnt, BUSY);
      rd_nv(p, p, "R5 wiper to nv");
    end

    // R6: stores during the busy window are discarded, window not extended
    busy_cnt = 0;
    txn2({4'b1100, 2'd2, 2'd1}, 8'h15, rx);
    exp_nv[6] = 6'h15;
    chk("R6 busy seen", nv_busy, 1'b1);
    txn2({4'b1100, 2'd2, 2'd1}, 8'h2A, rx);
    txn1({4'b1110, 2'd3, 2'd1});
    chk("R6 still busy", nv_busy, 1'b1);
    wait_idle();
    chk("R6 single window", busy_cnt, BUSY);
    rd_nv(1, 2, "R6 refused store");
    rd_nv(1, 3, "R6 refused copy");

    // R7: stepping, both rails and mixed patterns across two bytes
    txn2({4'b1010, 2'b00, 2'd2}, 8'd60, rx);
    exp_w[2] = 6'd60;
    pat = 8'hFF;
    sel_on();
    xbits({4'b0010, 2'b00, 2'd2}, 8, rx);
    xbits(pat, 8, rx);
    for (int b = 7; b >= 0; b--) exp_w[2] = step_model(exp_w[2], pat[b]);
    chk("R7 top rail", wiper_taps, packed_exp());
    pat = 8'hF0;
    xbits(pat, 8, rx);
    for (int b = 7; b >= 0; b--) exp_w[2] = step_model(exp_w[2], pat[b]);
    sel_off();
    chk("R7 down from top", wiper_taps, packed_exp());
    txn2({4'b1010, 2'b00, 2'd1}, 8'd2, rx);
    exp_w[1] = 6'd2;
    for (int k = 0; k < 3; k++) begin
      pat = (k == 0) ? 8'h00 : (k == 1) ? 8'hA5 : 8'h3C;
      txn2({4'b0010, 2'b00, 2'd1}, pat, rx);
      for (int b = 7; b >= 0; b--) exp_w[1] = step_model(exp_w[1], pat[b]);
      chk("R7 step pattern", wiper_taps, packed_exp());
    end

    // R8: undefined codes do nothing
    for (int op = 0; op < 16; op++) begin
      if (op == 2 || (op >= 9 && op <= 14)) continue;
      busy_cnt = 0;
      sel_on();
      xbits({4'(op), 4'b0101}, 8, rx);
      xbits(8'hFF, 8, rx);
      xbits(8'h2A, 8, rx);
      sel_off();
      chk("R8 taps unchanged", wiper_taps, packed_exp());
      chk("R8 no store", busy_cnt, 0);
    end

    // R9: abort partial data byte, partial instruction, and stepping
    sel_on();
    xbits({4'b1010, 2'b00, 2'd3}, 8, rx);
    xbits(8'h15, 5, rx);
    sel_off();
    chk("R9 partial data", wiper_taps, packed_exp());
    sel_on();
    xbits(8'hA3, 3, rx);
    sel_off();
    txn2({4'b1010, 2'b00, 2'd3}, 8'd17, rx);
    exp_w[3] = 6'd17;
    chk("R9 fresh after partial cmd", wiper_taps, packed_exp());
    sel_on();
    xbits({4'b0010, 2'b00, 2'd0}, 8, rx);
    xbits(8'h81, 8, rx);
    xbits(8'hE0, 3, rx);
    sel_off();
    exp_w[0] = step_model(exp_w[0], 1'b1);
    for (int b = 0; b < 6; b++) exp_w[0] = step_model(exp_w[0], 1'b0);
    exp_w[0] = step_model(exp_w[0], 1'b1);
    for (int b = 0; b < 3; b++) exp_w[0] = step_model(exp_w[0], 1'b1);
    chk("R9 stepping taps", wiper_taps, packed_exp());
    rd_wiper(0, "R9 new instruction after step");
    rd_wiper(2, "R1 channel field");

    finish_run();
  end
endmodule